// File: doc/BRIEF.md
# Divide-by-Eleven Unit

This block divides an unsigned N-bit dividend by the fixed constant eleven and returns both the floor quotient and the remainder. It uses no divide algorithm and no hard multiplier. The dividend is scaled by a short seed fraction, 93/1024, built from four shifted copies. A chain of refinement stages then multiplies that seed by (1 + 2^-10), (1 + 2^-20) and so on. Each stage doubles the run of correct fraction bits, because 1/11 equals 93/1023 and its binary expansion repeats every ten bits.

The number of refinement stages comes from N, so that at least N+4 fraction bits are correct. The estimate is always equal to the true quotient or one below it. A closing fix-up stage forms the residue of the dividend minus eleven times the estimate. If that residue is eleven or more, it adds one to the quotient and takes eleven off the residue. Every adder stage ends in a register, so the unit takes one dividend per cycle. Results come out in order, with a fixed latency.

Top module: `div11_unit`

## Requirements
- R1: For every valid dividend x, out_quot equals floor(x / 11).
- R2: For every valid dividend x, out_rem equals x mod 11, which always lies in 0..10.
- R3: out_valid rises exactly LAT clock cycles after the in_valid that carries a dividend, and the matching result is on out_quot/out_rem in that cycle. LAT = 3 + K, where K is the smallest count with 10·2^K >= N+4. This gives LAT = 5 for N = 32 and LAT = 4 for N = 16.
- R4: A new dividend is accepted on every clock with no stall. Results leave in the order the dividends entered.
- R5: A synchronous active-high rst clears every pending valid. out_valid is 0 on the clock after rst is sampled, and it stays 0 until a dividend presented after reset has travelled the full latency.
- R6: The edge dividends give exact results: 0, 10, 11 and 2^N−1. For N = 32 these are (0,0), (0,10), (1,0) and (390451572,3). For N = 16 they are (0,0), (0,10), (1,0) and (5957,8).
- R7: A cycle with in_valid low produces a cycle with out_valid low LAT cycles later, whatever data sat on in_dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Dividend strobe |
| in_dividend | input | N | Unsigned dividend |
| out_valid | output | 1 | Result strobe, LAT cycles after in_valid |
| out_quot | output | N | floor(dividend / 11) |
| out_rem | output | 4 | dividend mod 11 |

## Verification
Every result is due exactly LAT clocks after the edge that captured its dividend: five for the 32-bit instance and four for the 16-bit one. The bench queues each dividend and its strobe as it drives them on a falling edge. It pops the entry only once the queue holds LAT items, so each comparison lands on the falling edge after the register that presents the result. While the queue is shorter than LAT, as after a reset, only a low out_valid is accepted. The 16-bit instance is fed every value back to back. The 32-bit instance gets edge values, random values and gap cycles.

// File: rtl/div11_pkg.sv
package div11_pkg;

   // Refinement stages needed so that 10*2^k correct bits cover n+4 bits.
   function automatic int refine_count(input int n);
      int k;
      k = 0;
      while ((10 << k) < n + 4) k++;
      return k;
   endfunction

   // Fraction bits carried by the estimate (guard bits below the binary point).
   function automatic int frac_bits(input int n);
      return n + 4;
   endfunction

   // Low dividend bits needed for the modulo-32 residue check.
   localparam int RES_BITS = 5;

endpackage

// File: rtl/div11_seed.sv
module div11_seed
   import div11_pkg::*;
#(
   parameter int N = 32,
   parameter int F = frac_bits(N),
   localparam int W = N + F
) (
   input  logic                clk,
   input  logic [N-1:0]        x_i,
   output logic [W-1:0]        est_o,
   output logic [RES_BITS-1:0] lsb_o
);

   logic [W-1:0] scaled;
   logic [W-1:0] seed;

   // x * 93/1024 = x/8 - x/32 - x/512 - x/1024, exact because F >= 10
   always_comb begin
      scaled = {x_i, {F{1'b0}}};
      seed   = (scaled >> 3) - (scaled >> 5) - (scaled >> 9) - (scaled >> 10);
   end

   always_ff @(posedge clk) begin
      est_o <= seed;
      lsb_o <= x_i[RES_BITS-1:0];
   end

endmodule

// File: rtl/div11_refine.sv
module div11_refine
   import div11_pkg::*;
#(
   parameter int W     = 68,
   parameter int SHIFT = 10
) (
   input  logic                clk,
   input  logic [W-1:0]        est_i,
   input  logic [RES_BITS-1:0] lsb_i,
   output logic [W-1:0]        est_o,
   output logic [RES_BITS-1:0] lsb_o
);

   // Multiply the running estimate by (1 + 2^-SHIFT); truncation only lowers it.
   always_ff @(posedge clk) begin
      est_o <= est_i + (est_i >> SHIFT);
      lsb_o <= lsb_i;
   end

endmodule

// File: rtl/div11_fixup.sv
module div11_fixup
   import div11_pkg::*;
#(
   parameter int N = 32,
   parameter int F = frac_bits(N),
   localparam int W = N + F
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mid_valid,
   input  logic [W-1:0]        est_i,
   input  logic [RES_BITS-1:0] lsb_i,
   output logic [N-1:0]        quot_o,
   output logic [3:0]          rem_o
);

   logic [N-1:0]          q_trunc;
   logic [RES_BITS-1:0]   q_low;
   logic [RES_BITS-1:0]   times11;
   logic [RES_BITS-1:0]   resid;
   logic                  unused_frac;

   logic [N-1:0]          q_mid;
   logic [RES_BITS-1:0]   r_mid;

   logic                  bump;
   logic [RES_BITS-1:0]   r_fixed;
   logic                  unused_rtop;

   // Stage A: residue x - 11*q, computed modulo 32 (true value is 0..21)
   always_comb begin
      q_trunc     = est_i[W-1:F];
      unused_frac = ^est_i[F-1:0];
      q_low       = q_trunc[RES_BITS-1:0];
      times11     = (q_low << 3) + (q_low << 1) + q_low;
      resid       = lsb_i - times11;
   end

   always_ff @(posedge clk) begin
      q_mid <= q_trunc;
      r_mid <= resid;
   end

   // Stage B: one conditional correction
   always_comb begin
      bump        = (r_mid >= RES_BITS'(11));
      r_fixed     = bump ? (r_mid - RES_BITS'(11)) : r_mid;
      unused_rtop = r_fixed[RES_BITS-1];
   end

   always_ff @(posedge clk) begin
      quot_o <= q_mid + N'(bump);
      rem_o  <= r_fixed[3:0];
   end

   // The reciprocal chain may fall short by at most one quotient step.
   p_est_window_r1: assert property (@(posedge clk) disable iff (rst)
      mid_valid |-> (r_mid < RES_BITS'(22)));

endmodule

// File: rtl/div11_unit.sv
module div11_unit
   import div11_pkg::*;
#(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   input  logic [N-1:0] in_dividend,
   output logic         out_valid,
   output logic [N-1:0] out_quot,
   output logic [3:0]   out_rem
);

   localparam int F   = frac_bits(N);
   localparam int W   = N + F;
   localparam int K   = refine_count(N);
   localparam int LAT = 3 + K;
   localparam int EW  = N + 4;

   generate
      if (N < 8) begin : g_bad_width
         $error("div11_unit: N must be at least 8");
      end
   endgenerate

   logic [W-1:0]        est_c [0:K];
   logic [RES_BITS-1:0] lsb_c [0:K];
   logic [LAT-1:0]      vld;

   div11_seed #(.N(N), .F(F)) u_seed (
      .clk   (clk),
      .x_i   (in_dividend),
      .est_o (est_c[0]),
      .lsb_o (lsb_c[0])
   );

   for (genvar k = 0; k < K; k++) begin : g_refine
      div11_refine #(.W(W), .SHIFT(10 << k)) u_refine (
         .clk   (clk),
         .est_i (est_c[k]),
         .lsb_i (lsb_c[k]),
         .est_o (est_c[k+1]),
         .lsb_o (lsb_c[k+1])
      );
   end

   div11_fixup #(.N(N), .F(F)) u_fixup (
      .clk       (clk),
      .rst       (rst),
      .mid_valid (vld[LAT-2]),
      .est_i     (est_c[K]),
      .lsb_i     (lsb_c[K]),
      .quot_o    (out_quot),
      .rem_o     (out_rem)
   );

   // Only the strobe pipeline is reset; data registers free-run.
   always_ff @(posedge clk) begin
      if (rst) vld <= '0;
      else     vld <= {vld[LAT-2:0], in_valid};
   end

   assign out_valid = vld[LAT-1];

   p_rem_bound_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_rem < 4'd11));

   p_recompose_r1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (({4'b0, out_quot} * EW'(11)) + EW'(out_rem)
                     == {4'b0, $past(in_dividend, LAT)}));

   p_valid_delay_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, LAT));

endmodule

// File: tb/div11_unit_tb.sv
module div11_unit_tb;

   localparam int LAT32 = 5;
   localparam int LAT16 = 4;

   logic        clk = 1'b0;
   logic        rst;
   logic        v32, v16;
   logic [31:0] x32;
   logic [15:0] x16;
   logic        ov32, ov16;
   logic [31:0] q32;
   logic [15:0] q16;
   logic [3:0]  r32, r16;

   int tests = 0;
   int fails = 0;

   bit          qv32 [$];
   logic [31:0] qx32 [$];
   bit          qv16 [$];
   logic [15:0] qx16 [$];

   always #10 clk = ~clk;

   div11_unit #(.N(32)) u_dut (
      .clk(clk), .rst(rst), .in_valid(v32), .in_dividend(x32),
      .out_valid(ov32), .out_quot(q32), .out_rem(r32));

   div11_unit #(.N(16)) u_dut16 (
      .clk(clk), .rst(rst), .in_valid(v16), .in_dividend(x16),
      .out_valid(ov16), .out_quot(q16), .out_rem(r16));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_outs();
      bit          ev;
      logic [31:0] ex;
      logic [15:0] ey;
      if (qv32.size() == LAT32) begin
         ev = qv32.pop_front();
         ex = qx32.pop_front();
         if (ev) begin
            chk(ov32 == 1'b1, "R3", "out_valid32", ov32, 1);
            chk(q32 == ex / 32'd11, (ex inside {0, 10, 11, 32'hFFFFFFFF}) ? "R6" : "R1",
                "quot32", longint'(q32), longint'(ex / 32'd11));
            chk(r32 == 4'(ex % 32'd11), "R2", "rem32", longint'(r32), longint'(ex % 32'd11));
         end else begin
            chk(ov32 == 1'b0, "R7", "gap out_valid32", ov32, 0);
         end
      end else begin
         chk(ov32 == 1'b0, "R5", "post-reset out_valid32", ov32, 0);
      end
      if (qv16.size() == LAT16) begin
         ev = qv16.pop_front();
         ey = qx16.pop_front();
         if (ev) begin
            chk(ov16 == 1'b1, "R3", "out_valid16", ov16, 1);
            chk(q16 == ey / 16'd11, (ey inside {0, 10, 11, 16'hFFFF}) ? "R6" : "R1/R4",
                "quot16", longint'(q16), longint'(ey / 16'd11));
            chk(r16 == 4'(ey % 16'd11), "R2", "rem16", longint'(r16), longint'(ey % 16'd11));
         end else begin
            chk(ov16 == 1'b0, "R7", "gap out_valid16", ov16, 0);
         end
      end else begin
         chk(ov16 == 1'b0, "R5", "post-reset out_valid16", ov16, 0);
      end
   endtask

   task automatic step(input bit nv32, input logic [31:0] nx32,
                       input bit nv16, input logic [15:0] nx16);
      @(negedge clk);
      check_outs();
      v32 = nv32; x32 = nx32; v16 = nv16; x16 = nx16;
      qv32.push_back(nv32); qx32.push_back(nx32);
      qv16.push_back(nv16); qx16.push_back(nx16);
   endtask

   function automatic logic [31:0] edge32(input int i);
      case (i)
         0: return 32'd0;
         1: return 32'd10;
         2: return 32'd11;
         3: return 32'hFFFFFFFF;
         4: return 32'd21;
         5: return 32'd22;
         6: return 32'hFFFFFFF5;
         default: return 32'd12;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst = 1'b1; v32 = 1'b0; v16 = 1'b0; x32 = '0; x16 = '0;
      repeat (3) @(negedge clk);
      chk(ov32 == 1'b0, "R5", "reset out_valid32", ov32, 0);
      chk(ov16 == 1'b0, "R5", "reset out_valid16", ov16, 0);
      rst = 1'b0;

      // Exhaustive back-to-back on N=16; edges, random and gaps on N=32
      for (int i = 0; i < 65536; i++) begin
         logic [31:0] d32;
         bit          g32;
         d32 = (i < 8) ? edge32(i) : $urandom;
         g32 = (i < 8) ? 1'b1 : ((i % 7) != 3);
         step(g32, d32, 1'b1, 16'(i));
      end
      for (int i = 0; i < LAT32 + 2; i++) step(1'b0, $urandom, 1'b0, 16'($urandom));

      // Reset in the middle of a stream of valid dividends (R5)
      for (int i = 0; i < 3; i++) step(1'b1, 32'd1000 + 32'(i), 1'b1, 16'd500 + 16'(i));
      @(negedge clk);
      rst = 1'b1; v32 = 1'b1; v16 = 1'b1;
      @(negedge clk);
      chk(ov32 == 1'b0, "R5", "mid-stream reset out_valid32", ov32, 0);
      chk(ov16 == 1'b0, "R5", "mid-stream reset out_valid16", ov16, 0);
      rst = 1'b0; v32 = 1'b0; v16 = 1'b0;
      qv32.delete(); qx32.delete(); qv16.delete(); qx16.delete();
      for (int i = 0; i < LAT32 + 3; i++) step(1'b0, $urandom, 1'b0, 16'($urandom));
      // A fresh edge dividend after reset still comes out on time
      step(1'b1, 32'hFFFFFFFF, 1'b1, 16'hFFFF);
      for (int i = 0; i < LAT32 + 1; i++) step(1'b0, 32'd0, 1'b0, 16'd0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule